// File: doc/BRIEF.md
# Unaligned Access SRAM Controller

This block connects a 32-bit requester to a word-organised SRAM whose rows are 32 bits wide and which has no per-byte write enables. The requester may read or write a byte, a halfword or a word at any byte address. The controller turns each request into the sequence of row cycles the SRAM needs. A full word written to a row boundary becomes one write cycle. Any narrower write, or any write that straddles two rows, becomes a read-modify-write of one row or of two consecutive rows. A read that straddles two rows fetches both rows and stitches the bytes together, so the requester receives the data in a single response beat.

Byte order is little-endian. The lowest addressed byte lands in bits [7:0] of the response. Byte and halfword read results are zero-extended. A strict-mode input makes the controller refuse misaligned requests: it returns an error response and touches no row. Requests and responses use valid/ready handshakes, and only one request is in flight at a time. A request that straddles the last row continues at row 0.

Top module: `ua_sram_ctrl`

## Requirements
- R1: A word write (req_size 2 or 3) at lane offset 0 (req_addr[1:0] = 0) takes exactly one SRAM cycle, a write of req_wdata to row req_addr[7:2], with no row read.
- R2: A write that fits inside one row and is not a full aligned word takes two SRAM cycles: a read of the row, then a write back. Only the addressed lanes change. The lane at offset k holds bits [8k+7:8k] of the row. req_size 0 is a byte and 1 is a halfword.
- R3: A write that straddles a row boundary (a halfword at offset 3, or a word at offset 1, 2 or 3) takes four SRAM cycles. The controller reads and writes back the first row (its upper lanes change), then reads and writes back the next row (its lower lanes change).
- R4: A read inside one row takes one SRAM read cycle. A read that straddles a row boundary takes two SRAM read cycles, and its result comes back in one response beat.
- R5: Read data is little-endian and right-justified. The byte at the request address sits in rsp_rdata[7:0], and the lanes above the access size read as zero. A write response carries rsp_rdata = 0.
- R6: With cfg_strict = 1 at acceptance, a misaligned request (a halfword at an odd address, or a word at a non-zero offset) gets rsp_err = 1 and rsp_rdata = 0. It causes no SRAM cycle and leaves memory unchanged. Aligned requests, and any request made with cfg_strict = 0, get rsp_err = 0.
- R7: A straddling access whose first row is the last row continues at row 0.
- R8: req_ready is high only while the controller is idle with no response pending. rsp_valid, rsp_rdata and rsp_err stay stable until rsp_ready is seen.
- R9: After reset, req_ready = 1, rsp_valid = 0 and mem_en = 0, and no SRAM cycle happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_strict | input | 1 | Reject misaligned requests when 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Read data, right-justified and zero-extended |
| rsp_err | output | 1 | Misaligned request rejected |
| mem_en | output | 1 | SRAM cycle enable |
| mem_we | output | 1 | SRAM write (read when 0) |
| mem_row | output | ADDR_W-2 | SRAM row address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after a read |

## Verification
The bench checks every lane offset with every access size. It counts SRAM cycles per request, so a controller that always does a read-modify-write, or that skips the second row of a straddling access, gives a cycle count that does not match. It reads back whole rows after partial writes, which catches a merge that writes the wrong lanes or shifts the wrong way. It also straddles the last row, where a controller that does not wrap would corrupt or return the wrong row. Strict-mode requests are mixed with normal ones, and rows are read back after a rejected write, so a fault that still reaches memory shows up. A random stall on rsp_ready exposes responses that change while they are held.

// File: rtl/ua_pkg.sv
package ua_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WFULL,
    ST_RDA,
    ST_CAPA,
    ST_RDB,
    ST_CAPB,
    ST_RSP
  } ua_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/ua_req_decode.sv
module ua_req_decode #(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic [1:0]         size,
  input  logic [OFF_W-1:0]   off,
  output logic [LANES-1:0]   base_mask,
  output logic [2*LANES-1:0] lane_mask,
  output logic               misaligned,
  output logic               span2,
  output logic               full_row
);
  import ua_pkg::*;

  logic [OFF_W-1:0] align_bits;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        base_mask  = LANES'(4'h1);
        align_bits = '0;
      end
      SZ_HALF: begin
        base_mask  = LANES'(4'h3);
        align_bits = OFF_W'(1);
      end
      default: begin
        base_mask  = LANES'(4'hF);
        align_bits = OFF_W'(3);
      end
    endcase
  end

  assign lane_mask  = {{LANES{1'b0}}, base_mask} << off;
  assign misaligned = |(off & align_bits);
  assign span2      = |lane_mask[2*LANES-1:LANES];
  assign full_row   = &lane_mask[LANES-1:0];

endmodule

// File: rtl/ua_wmerge.sv
module ua_wmerge #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  old_row,
  input  logic [OFF_W-1:0]   off,
  input  logic [2*LANES-1:0] lane_mask,
  input  logic               hi_row,
  output logic [DATA_W-1:0]  new_row
);
  logic [2*DATA_W-1:0] wide;
  logic [DATA_W-1:0]   sel_data;
  logic [LANES-1:0]    sel_mask;

  assign wide     = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
  assign sel_data = hi_row ? wide[2*DATA_W-1:DATA_W] : wide[DATA_W-1:0];
  assign sel_mask = hi_row ? lane_mask[2*LANES-1:LANES] : lane_mask[LANES-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign new_row[8*g +: 8] = sel_mask[g] ? sel_data[8*g +: 8] : old_row[8*g +: 8];
  end

endmodule

// File: rtl/ua_rextract.sv
module ua_rextract #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [2*DATA_W-1:0] pair,
  input  logic [OFF_W-1:0]    off,
  input  logic [LANES-1:0]    base_mask,
  output logic [DATA_W-1:0]   data
);
  logic [DATA_W-1:0] shifted;

  assign shifted = DATA_W'(pair >> {off, 3'b000});

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data[8*g +: 8] = base_mask[g] ? shifted[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/ua_sram_ctrl.sv
module ua_sram_ctrl #(
  parameter  int ADDR_W = 8,
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_strict,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ROW_W-1:0]  mem_row,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import ua_pkg::*;

  // reset synchroniser: assert asynchronously, release on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // request decode (on the incoming request)
  logic [LANES-1:0]   dec_base;
  logic [2*LANES-1:0] dec_lanes;
  logic               dec_mis, dec_span, dec_full;

  ua_req_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_decode (
    .size       (req_size),
    .off        (req_addr[OFF_W-1:0]),
    .base_mask  (dec_base),
    .lane_mask  (dec_lanes),
    .misaligned (dec_mis),
    .span2      (dec_span),
    .full_row   (dec_full)
  );

  // registered request context
  ua_state_e          state_q, state_d;
  logic [ROW_W-1:0]   row_q;
  logic [OFF_W-1:0]   off_q;
  logic               write_q, span_q, full_q, err_q;
  logic [DATA_W-1:0]  wdata_q, lo_q, rdata_q;
  logic [LANES-1:0]   base_q;
  logic [2*LANES-1:0] lanes_q;

  logic accept, fault, ld_lo, ld_rdata;
  logic in_b;
  logic [DATA_W-1:0] merged, extracted;

  assign accept = req_valid & req_ready;
  assign fault  = cfg_strict & dec_mis;
  assign in_b   = (state_q == ST_RDB) || (state_q == ST_CAPB);

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (fault)                  state_d = ST_RSP;
          else if (req_write && dec_full) state_d = ST_WFULL;
          else                        state_d = ST_RDA;
        end
      end
      ST_WFULL: state_d = ST_RSP;
      ST_RDA:   state_d = ST_CAPA;
      ST_CAPA:  state_d = span_q ? ST_RDB : ST_RSP;
      ST_RDB:   state_d = ST_CAPB;
      ST_CAPB:  state_d = ST_RSP;
      ST_RSP:   if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // load enables
  assign ld_lo    = (state_q == ST_CAPA) && !write_q;
  assign ld_rdata = !write_q &&
                    (((state_q == ST_CAPA) && !span_q) || (state_q == ST_CAPB));

  // datapath helpers
  ua_wmerge #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_wmerge (
    .wdata     (wdata_q),
    .old_row   (mem_rdata),
    .off       (off_q),
    .lane_mask (lanes_q),
    .hi_row    (state_q == ST_CAPB),
    .new_row   (merged)
  );

  ua_rextract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_rextract (
    .pair      ((state_q == ST_CAPB) ? {mem_rdata, lo_q} : {{DATA_W{1'b0}}, mem_rdata}),
    .off       (off_q),
    .base_mask (base_q),
    .data      (extracted)
  );

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      off_q   <= '0;
      write_q <= 1'b0;
      span_q  <= 1'b0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
      base_q  <= '0;
      lanes_q <= '0;
      lo_q    <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        row_q   <= req_addr[ADDR_W-1:OFF_W];
        off_q   <= req_addr[OFF_W-1:0];
        write_q <= req_write;
        span_q  <= dec_span;
        full_q  <= dec_full;
        err_q   <= fault;
        wdata_q <= req_wdata;
        base_q  <= dec_base;
        lanes_q <= dec_lanes;
        rdata_q <= '0;
      end else if (ld_rdata) begin
        rdata_q <= extracted;
      end
      if (ld_lo) lo_q <= mem_rdata;
    end
  end

  // outputs
  logic cap_wr;
  assign cap_wr = write_q && ((state_q == ST_CAPA) || (state_q == ST_CAPB));

  assign req_ready = srst_n && (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RSP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  assign mem_en    = (state_q == ST_WFULL) || (state_q == ST_RDA) ||
                     (state_q == ST_RDB) || cap_wr;
  assign mem_we    = (state_q == ST_WFULL) || cap_wr;
  assign mem_row   = in_b ? ROW_W'(row_q + 1'b1) : row_q;
  assign mem_wdata = (state_q == ST_WFULL && full_q) ? wdata_q : merged;

endmodule

// File: rtl/ua_sram_ctrl_chk.sv
module ua_sram_ctrl_chk #(
  parameter  int ADDR_W = 8,
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_strict,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ROW_W-1:0]  mem_row,
  input logic [DATA_W-1:0] mem_wdata
);
  logic take, mis_in;
  assign take   = req_valid && req_ready;
  assign mis_in = (req_size == 2'd1 && req_addr[0]) ||
                  (req_size[1] && req_addr[OFF_W-1:0] != '0);

  // R8
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R6
  strict_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_strict && mis_in) |=> (rsp_valid && rsp_err && !mem_en));

  // R1
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && req_size[1] && req_addr[OFF_W-1:0] == '0 && LANES == 4)
    |=> (mem_en && mem_we && mem_row == $past(req_addr[ADDR_W-1:OFF_W])
         && mem_wdata == $past(req_wdata)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_en && !rsp_valid));

endmodule

bind ua_sram_ctrl ua_sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_strict (cfg_strict),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_row    (mem_row),
  .mem_wdata  (mem_wdata)
);

// File: tb/ua_sram_ctrl_bench.sv
`timescale 1ns/1ps
module ua_sram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int ROWS   = 1 << (ADDR_W - 2);
  localparam int NBYTES = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_strict = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_rdata;
  logic rsp_err;
  logic mem_en, mem_we;
  logic [ADDR_W-3:0] mem_row;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ua_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ua_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_strict(cfg_strict),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // SRAM model: one-cycle read latency, no byte enables
  logic [DATA_W-1:0] sram [ROWS];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[mem_row] <= mem_wdata;
      else        mem_rdata <= sram[mem_row];
    end
  end

  // reference byte memory
  logic [7:0] ref_mem [NBYTES];

  int n_cmp = 0;
  int n_mis = 0;
  bit stall_mode = 1'b0;

  logic [31:0] exp_data_q[$];
  logic        exp_err_q[$];
  int          exp_acc_q[$];
  string       exp_rq_q[$];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) rsp_ready <= stall_mode ? ($urandom % 3 != 0) : 1'b1;

  // monitor
  int acc_cnt = 0;
  bit hold_seen = 1'b0;
  logic [31:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en) acc_cnt++;
      if (rsp_valid && !rsp_ready && !hold_seen) begin
        held = rsp_rdata;
        hold_seen = 1'b1;
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_data_q.size() == 0) begin
          check(1'b0, "R8", "unexpected response", rsp_rdata, 32'h0);
        end else begin
          automatic logic [31:0] ed = exp_data_q.pop_front();
          automatic logic ee = exp_err_q.pop_front();
          automatic int ea = exp_acc_q.pop_front();
          automatic string rq = exp_rq_q.pop_front();
          check(rsp_rdata === ed, rq, "data", rsp_rdata, ed);
          check(rsp_err === ee, rq, "err", {31'b0, rsp_err}, {31'b0, ee});
          check(acc_cnt == ea, rq, "sram cycles", acc_cnt, ea);
          if (hold_seen) check(rsp_rdata === held, "R8", "held data", rsp_rdata, held);
        end
        hold_seen = 1'b0;
        acc_cnt = 0;
      end
    end
  end

  task automatic do_req(input logic wr, input logic [1:0] sz, input logic [7:0] addr,
                        input logic [31:0] wd, input logic strict, input string rq);
    int cnt, off, acc;
    bit mis, span;
    logic [31:0] ed;
    cnt  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    off  = int'(addr[1:0]);
    mis  = (off % cnt) != 0;
    span = (off + cnt) > 4;
    ed   = 32'h0;
    if (strict && mis) begin
      acc = 0;
    end else if (wr) begin
      for (int i = 0; i < cnt; i++) ref_mem[(int'(addr) + i) % NBYTES] = wd[8*i +: 8];
      acc = (cnt == 4 && off == 0) ? 1 : (span ? 4 : 2);
    end else begin
      for (int i = 0; i < cnt; i++) ed[8*i +: 8] = ref_mem[(int'(addr) + i) % NBYTES];
      acc = span ? 2 : 1;
    end
    exp_data_q.push_back(ed);
    exp_err_q.push_back(strict && mis);
    exp_acc_q.push_back(acc);
    exp_rq_q.push_back(rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
    req_wdata = wd; cfg_strict = strict;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8", "ready after accept", {31'b0, req_ready}, 32'h0);
  endtask

  task automatic wait_idle();
    while (exp_data_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    for (int b = 0; b < NBYTES; b++) ref_mem[b] = 8'(b * 7 + 3) ^ 8'h5A;
    for (int r = 0; r < ROWS; r++)
      sram[r] = {ref_mem[4*r+3], ref_mem[4*r+2], ref_mem[4*r+1], ref_mem[4*r]};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(req_ready === 1'b1, "R9", "req_ready", {31'b0, req_ready}, 32'h1);
    check(rsp_valid === 1'b0, "R9", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check(mem_en === 1'b0, "R9", "mem_en", {31'b0, mem_en}, 32'h0);

    // R1 aligned word write, R4/R5 aligned read
    do_req(1, 2'd2, 8'h10, 32'hA1B2C3D4, 0, "R1");
    do_req(0, 2'd2, 8'h10, 32'h0, 0, "R4");
    do_req(1, 2'd3, 8'h14, 32'h01020304, 1, "R1");
    do_req(0, 2'd2, 8'h14, 32'h0, 1, "R5");

    // R2 byte writes at each lane, then whole-row readback
    for (int k = 0; k < 4; k++) do_req(1, 2'd0, 8'(8'h20 + k), 32'hFFFFFF00 | 32'(8'h90 + k), 0, "R2");
    do_req(0, 2'd2, 8'h20, 32'h0, 0, "R2");
    do_req(1, 2'd1, 8'h25, 32'h0000BEEF, 0, "R2");
    do_req(0, 2'd2, 8'h24, 32'h0, 0, "R2");
    // R5 zero extension of narrow reads
    for (int k = 0; k < 4; k++) do_req(0, 2'd0, 8'(8'h20 + k), 32'h0, 0, "R5");
    do_req(0, 2'd1, 8'h26, 32'h0, 0, "R5");

    // R3 straddling writes, R4 straddling reads
    do_req(1, 2'd1, 8'h33, 32'h00005566, 0, "R3");
    do_req(0, 2'd2, 8'h30, 32'h0, 0, "R3");
    do_req(0, 2'd2, 8'h34, 32'h0, 0, "R3");
    for (int k = 1; k < 4; k++) begin
      do_req(1, 2'd2, 8'(8'h40 + 8*k + k), 32'hC0DE0000 | 32'(k), 0, "R3");
      do_req(0, 2'd2, 8'(8'h40 + 8*k), 32'h0, 0, "R3");
      do_req(0, 2'd2, 8'(8'h44 + 8*k), 32'h0, 0, "R3");
      do_req(0, 2'd2, 8'(8'h40 + 8*k + k), 32'h0, 0, "R4");
    end
    do_req(0, 2'd1, 8'h47, 32'h0, 0, "R4");

    // R6 strict rejection, memory untouched
    do_req(1, 2'd1, 8'h51, 32'h0000DEAD, 1, "R6");
    do_req(1, 2'd2, 8'h56, 32'hDEADBEEF, 1, "R6");
    do_req(0, 2'd2, 8'h53, 32'h0, 1, "R6");
    do_req(0, 2'd2, 8'h50, 32'h0, 0, "R6");
    do_req(0, 2'd2, 8'h54, 32'h0, 0, "R6");
    do_req(1, 2'd0, 8'h53, 32'h000000AB, 1, "R6");
    do_req(0, 2'd1, 8'h52, 32'h0, 1, "R6");
    do_req(0, 2'd1, 8'h51, 32'h0, 0, "R6");

    // R7 wrap from last row to row 0
    do_req(1, 2'd2, 8'hFE, 32'h7A7B7C7D, 0, "R7");
    do_req(0, 2'd2, 8'hFC, 32'h0, 0, "R7");
    do_req(0, 2'd2, 8'h00, 32'h0, 0, "R7");
    do_req(0, 2'd2, 8'hFD, 32'h0, 0, "R7");
    do_req(0, 2'd1, 8'hFF, 32'h0, 0, "R7");
    wait_idle();

    // R8 random traffic with response stalls
    stall_mode = 1'b1;
    for (int n = 0; n < 300; n++)
      do_req(1'($urandom % 2), 2'($urandom % 4), 8'($urandom), $urandom,
             ($urandom % 4) == 0, "R8");
    wait_idle();
    stall_mode = 1'b0;
    for (int r = 0; r < 8; r++) do_req(0, 2'd2, 8'(r * 4), 32'h0, 0, "R2");
    wait_idle();
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule